// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a processor's memory-mapped slave bus to a 256K x 16 asynchronous static RAM. It watches the bus select and the upper address bits. When a request falls inside its own window, it captures the request and drives the SRAM chip-enable, output-enable, write-enable and word address. For a write, it also drives the shared bidirectional data pins. Reads return the sampled word and writes are confirmed, both through a single-cycle acknowledge.

A four-state sequencer runs every access. Its states are IDLE, COMMON, WPULSE and XMIT. The transitions are:
- IDLE to COMMON on a window hit.
- COMMON to XMIT for a read, with the SRAM word captured on that edge.
- COMMON to WPULSE for a write.
- WPULSE to XMIT.
- XMIT to IDLE, unconditionally.

The bus master holds its request until it sees the acknowledge and then drops select. The memory is static and needs no refresh.

Top module: `sram_bus_ctrl`

## Requirements
- R1: During reset and after it, with no request, mem_ce_n, mem_oe_n and mem_we_n are high, bus_ack is low and the controller does not drive mem_dq. A reset in the middle of an access aborts it, and no write reaches the SRAM.
- R2: An access starts only when bus_sel is 1 and bus_addr[31:20] are all ones (window 0xFFF00000 upward; bits 19:18 are not decoded). Any other request leaves mem_ce_n high, gives no bus_ack and does not change the SRAM.
- R3: While mem_ce_n is low, mem_addr equals bus_addr[17:0] of the accepted request and stays constant.
- R4: Every access passes through COMMON first. If a request is presented before an accepting clock edge, bus_ack is high in the cycle after the next edge for a read (bus_rnw=1), and in the cycle after the second following edge for a write (bus_rnw=0).
- R5: On a read, mem_oe_n is low for exactly one cycle (COMMON), and the controller never drives mem_dq. The word on mem_dq is captured at the end of COMMON and appears on bus_rdata while bus_ack is high.
- R6: On a write, the controller drives bus_wdata on mem_dq from COMMON through XMIT. mem_we_n is low for exactly one cycle (WPULSE), never in the first cycle of the access, and rises while the data is still driven.
- R7: bus_ack is high for exactly one cycle per accepted access (XMIT), after which the controller returns to IDLE and releases mem_ce_n.
- R8: mem_we_n and mem_oe_n are never low together, and mem_we_n is low only while mem_ce_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus select qualifying the request |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 32 | Byte-agnostic bus address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_ack on a read |
| bus_ack | output | 1 | One-cycle access acknowledge |
| mem_ce_n | output | 1 | SRAM chip enable, active low |
| mem_oe_n | output | 1 | SRAM output enable, active low |
| mem_we_n | output | 1 | SRAM write enable, active low |
| mem_addr | output | 18 | SRAM word address |
| mem_dq | inout | 16 | SRAM bidirectional data |

## Verification
The bench presents writes and reads at interior addresses and at both ends of the window, then reads each word back. Correct data separates good address routing and capture timing from an off-by-one strobe. Requests with a clear upper address bit, and requests with bus_sel low, are each followed by a read of the location they named. That read shows whether the decode, or the select qualification alone, blocks the access. Acknowledge latency and strobe widths are counted per access and tell the read path from the write path. A reset asserted in the middle of a write shows that the write pulse never reached the memory.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    localparam int BUS_AW   = 32;
    localparam int WORD_DW  = 16;
    localparam int MEM_AW   = 18;
    localparam int DEC_BITS = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMON = 2'd1,
        ST_WPULSE = 2'd2,
        ST_XMIT   = 2'd3
    } acc_state_t;
endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode #(
    parameter int BUS_AW   = 32,
    parameter int DEC_BITS = 12
) (
    input  logic              bus_sel,
    input  logic [BUS_AW-1:0] bus_addr,
    output logic              hit
);
    localparam int DEC_LSB = BUS_AW - DEC_BITS;

    always_comb begin
        hit = bus_sel && (&bus_addr[BUS_AW-1:DEC_LSB]);
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic req_rnw,
    output logic load,
    output logic cap_rd,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_en,
    output logic ack
);
    acc_state_t st_q, st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   st_d = hit ? ST_COMMON : ST_IDLE;
            ST_COMMON: st_d = req_rnw ? ST_XMIT : ST_WPULSE;
            ST_WPULSE: st_d = ST_XMIT;
            ST_XMIT:   st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load   = 1'b0;
        cap_rd = 1'b0;
        ce_n   = 1'b0;
        oe_n   = 1'b1;
        we_n   = 1'b1;
        dq_en  = 1'b0;
        ack    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                ce_n = 1'b1;
                load = hit;
            end
            ST_COMMON: begin
                oe_n   = !req_rnw;
                cap_rd = req_rnw;
                dq_en  = !req_rnw;
            end
            ST_WPULSE: begin
                we_n  = 1'b0;
                dq_en = 1'b1;
            end
            ST_XMIT: begin
                ack   = 1'b1;
                dq_en = !req_rnw;
            end
        endcase
    end
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int BUS_AW  = 32,
    parameter int WORD_DW = 16,
    parameter int MEM_AW  = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               cap_rd,
    input  logic               dq_en,
    input  logic               bus_rnw,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [WORD_DW-1:0] bus_wdata,
    output logic               req_rnw,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [WORD_DW-1:0] rdata,
    inout  wire  [WORD_DW-1:0] mem_dq
);
    logic [MEM_AW-1:0]  addr_q;
    logic [WORD_DW-1:0] wdata_q;
    logic [WORD_DW-1:0] rdata_q;
    logic               rnw_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rnw_q   <= 1'b1;
        end else if (load) begin
            addr_q  <= bus_addr[MEM_AW-1:0];
            wdata_q <= bus_wdata;
            rnw_q   <= bus_rnw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (cap_rd) rdata_q <= mem_dq;
    end

    assign mem_dq   = dq_en ? wdata_q : 'z;
    assign mem_addr = addr_q;
    assign rdata    = rdata_q;
    assign req_rnw  = rnw_q;
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
    parameter int BUS_AW   = sram_ctrl_pkg::BUS_AW,
    parameter int WORD_DW  = sram_ctrl_pkg::WORD_DW,
    parameter int MEM_AW   = sram_ctrl_pkg::MEM_AW,
    parameter int DEC_BITS = sram_ctrl_pkg::DEC_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_rnw,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [WORD_DW-1:0] bus_wdata,
    output logic [WORD_DW-1:0] bus_rdata,
    output logic               bus_ack,
    output logic               mem_ce_n,
    output logic               mem_oe_n,
    output logic               mem_we_n,
    output logic [MEM_AW-1:0]  mem_addr,
    inout  wire  [WORD_DW-1:0] mem_dq
);
    logic hit, load, cap_rd, dq_en, req_rnw;

    sram_addr_decode #(.BUS_AW(BUS_AW), .DEC_BITS(DEC_BITS)) u_dec (
        .bus_sel  (bus_sel),
        .bus_addr (bus_addr),
        .hit      (hit)
    );

    sram_ctrl_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .req_rnw (req_rnw),
        .load    (load),
        .cap_rd  (cap_rd),
        .ce_n    (mem_ce_n),
        .oe_n    (mem_oe_n),
        .we_n    (mem_we_n),
        .dq_en   (dq_en),
        .ack     (bus_ack)
    );

    sram_data_path #(.BUS_AW(BUS_AW), .WORD_DW(WORD_DW), .MEM_AW(MEM_AW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .cap_rd    (cap_rd),
        .dq_en     (dq_en),
        .bus_rnw   (bus_rnw),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req_rnw   (req_rnw),
        .mem_addr  (mem_addr),
        .rdata     (bus_rdata),
        .mem_dq    (mem_dq)
    );
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
    parameter int MEM_AW = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_ack,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              dq_en,
    input logic [MEM_AW-1:0] mem_addr
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);                                            // R7
    AST_ACK_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> !mem_ce_n);                                           // R7
    AST_NO_STROBE_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));                                       // R8
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);                                         // R8
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !dq_en);                                            // R5
    AST_WE_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(!mem_ce_n) && $past(dq_en)));          // R6
    AST_WE_RISE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> dq_en);                                       // R6
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));           // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !dq_en && !bus_ack));       // R1
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_ack  (bus_ack),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .dq_en    (dq_en),
    .mem_addr (mem_addr)
);

// File: tb/sram_bus_ctrl_tb_top.sv
module sram_bus_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic        rnw;
        logic        sel;
        logic [31:0] addr;
        logic [15:0] wd;
        logic [15:0] exp;
        logic        hit;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 32'hFFF00012, 16'h1234, 16'h0000, 1'b1},
        '{1'b0, 1'b1, 32'hFFF12345, 16'hBEEF, 16'h0000, 1'b1},
        '{1'b1, 1'b1, 32'hFFF00012, 16'h0000, 16'h1234, 1'b1},
        '{1'b1, 1'b1, 32'hFFF12345, 16'h0000, 16'hBEEF, 1'b1},
        '{1'b0, 1'b1, 32'hFFE00012, 16'hDEAD, 16'h0000, 1'b0},
        '{1'b0, 1'b0, 32'hFFF00012, 16'h0BAD, 16'h0000, 1'b0},
        '{1'b1, 1'b1, 32'hFFF00012, 16'h0000, 16'h1234, 1'b1},
        '{1'b0, 1'b1, 32'hFFF3FFFF, 16'h5A5A, 16'h0000, 1'b1},
        '{1'b0, 1'b1, 32'hFFF00000, 16'hA5A5, 16'h0000, 1'b1},
        '{1'b1, 1'b1, 32'hFFF3FFFF, 16'h0000, 16'h5A5A, 1'b1},
        '{1'b1, 1'b1, 32'hFFF00000, 16'h0000, 16'hA5A5, 1'b1},
        '{1'b1, 1'b1, 32'hFFF00077, 16'h0000, 16'hA077, 1'b1},
        '{1'b1, 1'b1, 32'h7FF00012, 16'h0000, 16'h0000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_rnw = 1'b1;
    logic [31:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_ack;
    logic        mem_ce_n, mem_oe_n, mem_we_n;
    logic [17:0] mem_addr;
    wire  [15:0] mem_dq;

    logic [15:0] model [256];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bus_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_rnw   (bus_rnw),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq)
    );

    // simple SRAM model, indexed by the low 8 word-address bits
    assign mem_dq = (!mem_ce_n && !mem_oe_n) ? model[mem_addr[7:0]] : 'z;

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 16'hA000 + 16'(i);
    end

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) model[mem_addr[7:0]] <= mem_dq;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        int ack_cnt = 0, ack_at = 0, we_cnt = 0, oe_cnt = 0;
        bit addr_ok = 1'b1, ce_seen = 1'b0, clash = 1'b0;
        logic [15:0] rd = '0;
        @(negedge clk);
        bus_sel   = v.sel;
        bus_rnw   = v.rnw;
        bus_addr  = v.addr;
        bus_wdata = v.wd;
        for (int n = 1; n <= 6; n++) begin
            @(negedge clk);
            if (!mem_ce_n) begin
                ce_seen = 1'b1;
                if (mem_addr !== v.addr[17:0]) addr_ok = 1'b0;
            end
            if (!mem_we_n) we_cnt++;
            if (!mem_oe_n) oe_cnt++;
            if (!mem_we_n && !mem_oe_n) clash = 1'b1;
            if (bus_ack) begin
                ack_cnt++;
                if (ack_at == 0) begin
                    ack_at = n;
                    rd = bus_rdata;
                end
                bus_sel = 1'b0;
            end
        end
        bus_sel = 1'b0;
        if (v.hit) begin
            chk(ack_cnt == 1, "R7", $sformatf("vec%0d ack count", idx), ack_cnt, 1);
            chk(ack_at == (v.rnw ? 2 : 3), "R4", $sformatf("vec%0d ack latency", idx),
                ack_at, v.rnw ? 2 : 3);
            chk(addr_ok, "R3", $sformatf("vec%0d mem_addr", idx), int'(mem_addr), int'(v.addr[17:0]));
            chk(!clash, "R8", $sformatf("vec%0d we/oe clash", idx), 1, 0);
            if (v.rnw) begin
                chk(rd == v.exp, "R5", $sformatf("vec%0d read data", idx), rd, v.exp);
                chk(oe_cnt == 1 && we_cnt == 0, "R5", $sformatf("vec%0d oe width", idx), oe_cnt, 1);
            end else begin
                chk(model[v.addr[7:0]] == v.wd, "R6", $sformatf("vec%0d stored word", idx),
                    model[v.addr[7:0]], v.wd);
                chk(we_cnt == 1 && oe_cnt == 0, "R6", $sformatf("vec%0d we width", idx), we_cnt, 1);
            end
        end else begin
            chk(ack_cnt == 0, "R2", $sformatf("vec%0d ack on miss", idx), ack_cnt, 0);
            chk(!ce_seen, "R2", $sformatf("vec%0d ce on miss", idx), ce_seen, 0);
        end
        chk(mem_ce_n && mem_we_n && mem_oe_n && !bus_ack, "R7",
            $sformatf("vec%0d back to idle", idx), {mem_ce_n, mem_we_n, mem_oe_n, bus_ack}, 4'b1110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !bus_ack, "R1", "strobes in reset",
            {mem_ce_n, mem_oe_n, mem_we_n, bus_ack}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !bus_ack, "R1", "strobes after reset",
            {mem_ce_n, mem_oe_n, mem_we_n, bus_ack}, 4'b1110);

        for (int i = 0; i < NVEC; i++) run_vec(VEC[i], i);

        // R1: reset during a write, after COMMON, before WPULSE commits
        @(negedge clk);
        bus_sel = 1'b1; bus_rnw = 1'b0; bus_addr = 32'hFFF00033; bus_wdata = 16'h7777;
        @(negedge clk);
        chk(!mem_ce_n && mem_we_n, "R6", "write not strobed in first cycle",
            {mem_ce_n, mem_we_n}, 2'b01);
        rst_n = 1'b0;
        bus_sel = 1'b0;
        @(negedge clk);
        chk(mem_ce_n && mem_we_n && !bus_ack, "R1", "abort on reset",
            {mem_ce_n, mem_we_n, bus_ack}, 3'b110);
        rst_n = 1'b1;
        @(negedge clk);
        chk(model[8'h33] == 16'hA033, "R1", "aborted write not stored", model[8'h33], 16'hA033);
        run_vec('{1'b1, 1'b1, 32'hFFF00033, 16'h0000, 16'hA033, 1'b1}, 99);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule